// File: doc/BRIEF.md
# Bridge Response Packetizer

This block turns the result of a bridged SPI transaction into the device-to-host packets of the USB-to-SPI bridge protocol. It emits them as a byte stream with a valid/ready handshake and a marker on the final byte of each packet. A transfer response opens with a start packet that carries the status code and the first slice of the read buffer. Indexed continue packets follow until the whole read count has been sent. The block also produces the short configuration report and the chip-select acknowledgement.

The SPI engine fills the read buffer. It then raises a request with the response kind, the status and the read count. The packetizer fetches buffer bytes through a combinational address/data port while it streams. The last transfer response stays held, so a host that lost a packet can ask for a replay. The replay starts again from the start packet and reads the same buffer again, with no new SPI transaction.

Top module: `rsp_packetizer`

## Requirements
- R1: After reset, and again after the last byte of every response, `cmd_ready` is 1 and `out_valid` is 0. A request is taken only while `cmd_ready` is 1.
- R2: Every 16-bit field goes out low byte first. The second byte of every packet (the high byte of the packet id) is 0, and `out_last` marks the final byte of each packet.
- R3: A request of kind 0 (transfer) with status 0 and read count N (at most MAX_READ) opens with a start packet: id 5, the status, and then buffer bytes 0 up to min(N,60)-1. Its length is 4+min(N,60) bytes.
- R4: Further packets follow back to back until N bytes have gone out. Each carries id 6, then a 16-bit index equal to the payload bytes already sent, then up to 60 bytes. With N=100 this gives a 64-byte start and a 44-byte continue packet with index 60. With N=0 the only packet is the 4-byte start.
- R5: A transfer request with a nonzero status gives a single 4-byte start packet with no payload, whatever N is.
- R6: When `req_int_err` is 1, the status sent is 0x8000 with `req_status[14:0]` in the low 15 bits.
- R7: A request of kind 1 (configuration) gives 8 bytes: id 1, MAX_WRITE, MAX_READ, and a bitmap that holds `feat_caps` in bits 5:0 and zeros in bits 15:6.
- R8: A request of kind 2 (chip select) gives 4 bytes: id 8 followed by the status.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values. A byte advances only on a cycle where both are 1.
- R10: `restart_req` while idle, with a transfer response held, replays the full transfer response byte for byte from its start packet.
- R11: `restart_req` has no effect after reset, after a configuration or chip-select response (both of these drop the held transfer), or while a response is streaming. A request of kind 3 produces no bytes and keeps the held transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Response request strobe |
| req_kind | input | 2 | 0 transfer, 1 configuration, 2 chip select, 3 none |
| req_status | input | 16 | Status code for transfer / chip-select responses |
| req_int_err | input | 1 | Wrap `req_status[14:0]` as an unknown-error status |
| req_rd_len | input | 16 | Read byte count of the transfer |
| feat_caps | input | 6 | Capability bits for the configuration bitmap |
| cmd_ready | output | 1 | Idle, request accepted |
| restart_req | input | 1 | Replay the held transfer response |
| rd_addr | output | 16 | Read buffer byte address |
| rd_data | input | 8 | Read buffer byte at `rd_addr` (combinational) |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a packet |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
A corrupted offset or byte position shows on the stream at once. A wrong index field appears in the third and fourth bytes of the first continue packet. A wrong chunk size moves `out_last` to the wrong byte of the first packet that is too long or too short. A lost held-response flag only shows on the next restart, as silence or as a stray replay. The bench therefore follows every kind of response with both honoured and ignored restarts. Stalls are checked byte by byte, so a pointer that moves while `out_ready` is low is seen on the very next sampled byte.

// File: rtl/rsp_pkt_pkg.sv
package rsp_pkt_pkg;

  localparam int FIELD_W = 16;
  localparam int POS_W   = 7;

  typedef enum logic [1:0] {
    KIND_XFER = 2'd0,
    KIND_CFG  = 2'd1,
    KIND_CS   = 2'd2,
    KIND_NONE = 2'd3
  } rsp_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } rsp_state_e;

  localparam logic [7:0] ID_CFG   = 8'd1;
  localparam logic [7:0] ID_START = 8'd5;
  localparam logic [7:0] ID_CONT  = 8'd6;
  localparam logic [7:0] ID_CS    = 8'd8;

  localparam logic [POS_W-1:0] HDR_LEN = 7'd4;
  localparam logic [POS_W-1:0] CFG_LEN = 7'd8;

  // Bytes that fit in the next packet: the remainder, capped at the payload size.
  function automatic logic [POS_W-1:0] chunk_len(input logic [FIELD_W-1:0] remaining,
                                                 input logic [POS_W-1:0] cap);
    logic [FIELD_W-1:0] wide_cap;
    wide_cap = {{(FIELD_W-POS_W){1'b0}}, cap};
    if (remaining > wide_cap) return cap;
    return remaining[POS_W-1:0];
  endfunction

  // Little-endian byte pick out of a 16-bit field.
  function automatic logic [7:0] field_byte(input logic [FIELD_W-1:0] v, input logic upper);
    return upper ? v[15:8] : v[7:0];
  endfunction

  // Status as sent: an internal error becomes bit 15 plus a 15-bit code.
  function automatic logic [FIELD_W-1:0] wire_status(input logic [FIELD_W-1:0] code,
                                                     input logic internal);
    return internal ? {1'b1, code[14:0]} : code;
  endfunction

endpackage

// File: rtl/rsp_seg_calc.sv
module rsp_seg_calc
  import rsp_pkt_pkg::*;
#(
  parameter int PAYLOAD = 60
) (
  input  rsp_kind_e          kind,
  input  logic [FIELD_W-1:0] total_len,
  input  logic [FIELD_W-1:0] sent_base,
  output logic [POS_W-1:0]   seg_len,
  output logic [POS_W-1:0]   pkt_len,
  output logic               more_pkts
);
  localparam logic [POS_W-1:0] CAP = POS_W'(PAYLOAD);

  logic [FIELD_W-1:0] remaining;
  logic [FIELD_W-1:0] after_seg;

  always_comb begin
    remaining = total_len - sent_base;
    seg_len   = (kind == KIND_XFER) ? chunk_len(remaining, CAP) : '0;
    after_seg = sent_base + {{(FIELD_W-POS_W){1'b0}}, seg_len};
    unique case (kind)
      KIND_XFER: pkt_len = HDR_LEN + seg_len;
      KIND_CFG:  pkt_len = CFG_LEN;
      default:   pkt_len = HDR_LEN;
    endcase
    more_pkts = (kind == KIND_XFER) && (after_seg < total_len);
  end
endmodule

// File: rtl/rsp_byte_mux.sv
module rsp_byte_mux
  import rsp_pkt_pkg::*;
#(
  parameter int MAX_WRITE = 298,
  parameter int MAX_READ  = 298,
  parameter int FEAT_W    = 6
) (
  input  rsp_kind_e          kind,
  input  logic               first_pkt,
  input  logic [POS_W-1:0]   pos,
  input  logic [FIELD_W-1:0] status,
  input  logic [FIELD_W-1:0] sent_base,
  input  logic [FEAT_W-1:0]  feat,
  input  logic [7:0]         buf_byte,
  output logic [FIELD_W-1:0] buf_addr,
  output logic [7:0]         byte_out
);
  localparam logic [FIELD_W-1:0] MAXW_F = FIELD_W'(MAX_WRITE);
  localparam logic [FIELD_W-1:0] MAXR_F = FIELD_W'(MAX_READ);

  logic [7:0]         pkt_id;
  logic [FIELD_W-1:0] field_a;
  logic [FIELD_W-1:0] field_b;
  logic               in_header;
  logic [FIELD_W-1:0] pos_wide;

  always_comb begin
    unique case (kind)
      KIND_XFER: pkt_id = first_pkt ? ID_START : ID_CONT;
      KIND_CFG:  pkt_id = ID_CFG;
      default:   pkt_id = ID_CS;
    endcase

    if (kind == KIND_CFG)                    field_a = MAXW_F;
    else if (kind == KIND_XFER && !first_pkt) field_a = sent_base;
    else                                      field_a = status;

    field_b   = pos[1] ? FIELD_W'(feat) : MAXR_F;
    in_header = (pos < HDR_LEN);
    pos_wide  = {{(FIELD_W-POS_W){1'b0}}, pos};
    buf_addr  = in_header ? sent_base : (sent_base + pos_wide - FIELD_W'(HDR_LEN));

    if (pos == '0)               byte_out = pkt_id;
    else if (pos == POS_W'(1))   byte_out = 8'h00;
    else if (in_header)          byte_out = field_byte(field_a, pos[0]);
    else if (kind == KIND_XFER)  byte_out = buf_byte;
    else                         byte_out = field_byte(field_b, pos[0]);
  end
endmodule

// File: rtl/rsp_packetizer.sv
module rsp_packetizer
  import rsp_pkt_pkg::*;
#(
  parameter int MAX_WRITE = 298,
  parameter int MAX_READ  = 298,
  parameter int PAYLOAD   = 60,
  parameter int FEAT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_status,
  input  logic              req_int_err,
  input  logic [15:0]       req_rd_len,
  input  logic [FEAT_W-1:0] feat_caps,
  output logic              cmd_ready,
  input  logic              restart_req,
  output logic [15:0]       rd_addr,
  input  logic [7:0]        rd_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready
);

  rsp_state_e         state_q;
  rsp_kind_e          kind_q;
  logic [FIELD_W-1:0] status_q;
  logic [FIELD_W-1:0] len_q;
  logic [FIELD_W-1:0] base_q;
  logic [POS_W-1:0]   pos_q;
  logic               first_q;
  logic [FEAT_W-1:0]  feat_q;
  logic               held_q;

  // Named internal events, observed by the bound checker.
  logic               sending;
  logic               req_take;
  logic               replay_take;
  logic               beat_fire;
  logic               pkt_sop;
  logic               pkt_eop;

  rsp_kind_e          req_kind_e;
  logic [FIELD_W-1:0] status_in;
  logic [POS_W-1:0]   seg_len;
  logic [POS_W-1:0]   pkt_len;
  logic               more_pkts;

  assign req_kind_e  = rsp_kind_e'(req_kind);
  assign status_in   = wire_status(req_status, req_int_err);
  assign sending     = (state_q == ST_SEND);
  assign cmd_ready   = (state_q == ST_IDLE);
  assign req_take    = cmd_ready && req_valid;
  assign replay_take = cmd_ready && !req_valid && restart_req && held_q;
  assign beat_fire   = sending && out_ready;
  assign pkt_sop     = sending && (pos_q == '0);
  assign pkt_eop     = sending && (pos_q == (pkt_len - POS_W'(1)));

  rsp_seg_calc #(
    .PAYLOAD (PAYLOAD)
  ) u_seg (
    .kind      (kind_q),
    .total_len (len_q),
    .sent_base (base_q),
    .seg_len   (seg_len),
    .pkt_len   (pkt_len),
    .more_pkts (more_pkts)
  );

  rsp_byte_mux #(
    .MAX_WRITE (MAX_WRITE),
    .MAX_READ  (MAX_READ),
    .FEAT_W    (FEAT_W)
  ) u_mux (
    .kind      (kind_q),
    .first_pkt (first_q),
    .pos       (pos_q),
    .status    (status_q),
    .sent_base (base_q),
    .feat      (feat_q),
    .buf_byte  (rd_data),
    .buf_addr  (rd_addr),
    .byte_out  (out_data)
  );

  assign out_valid = sending;
  assign out_last  = pkt_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= KIND_XFER;
      status_q <= '0;
      len_q    <= '0;
      base_q   <= '0;
      pos_q    <= '0;
      first_q  <= 1'b1;
      feat_q   <= '0;
      held_q   <= 1'b0;
    end else if (req_take) begin
      if (req_kind_e != KIND_NONE) begin
        state_q  <= ST_SEND;
        kind_q   <= req_kind_e;
        status_q <= status_in;
        len_q    <= (req_kind_e == KIND_XFER && status_in == '0) ? req_rd_len : '0;
        base_q   <= '0;
        pos_q    <= '0;
        first_q  <= 1'b1;
        feat_q   <= feat_caps;
        held_q   <= (req_kind_e == KIND_XFER);
      end
    end else if (replay_take) begin
      state_q <= ST_SEND;
      base_q  <= '0;
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (beat_fire) begin
      if (pkt_eop) begin
        if (more_pkts) begin
          base_q  <= base_q + {{(FIELD_W-POS_W){1'b0}}, seg_len};
          pos_q   <= '0;
          first_q <= 1'b0;
        end else begin
          state_q <= ST_IDLE;
        end
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/rsp_packetizer_chk.sv
module rsp_packetizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       pkt_sop
);
  logic [7:0] byte_cnt;
  logic       cfg_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      cfg_pkt  <= 1'b0;
    end else if (out_valid && out_ready) begin
      byte_cnt <= out_last ? 8'd0 : byte_cnt + 8'd1;
      if (byte_cnt == 8'd0) cfg_pkt <= (out_data == 8'd1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !out_valid);  // R1

  AST_SOP_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pkt_sop) |-> (out_data == 8'd1 || out_data == 8'd5 ||
                                out_data == 8'd6 || out_data == 8'd8));  // R2

  AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && byte_cnt == 8'd1) |-> (out_data == 8'd0));  // R2

  AST_PKT_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (byte_cnt < 8'd64));  // R3

  AST_PKT_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (byte_cnt >= 8'd3));  // R5

  AST_CFG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && byte_cnt != 8'd0 && cfg_pkt) |-> (byte_cnt == 8'd7));  // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));  // R9
endmodule

bind rsp_packetizer rsp_packetizer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_ready (out_ready),
  .pkt_sop   (pkt_sop)
);

// File: tb/rsp_packetizer_test.sv
module rsp_packetizer_test;
  localparam int MAXW = 298;
  localparam int MAXR = 298;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_status;
  logic        req_int_err;
  logic [15:0] req_rd_len;
  logic [5:0]  feat_caps;
  logic        cmd_ready;
  logic        restart_req;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready;

  logic [7:0] mem [0:511];
  assign rd_data = mem[rd_addr[8:0]];

  rsp_packetizer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_status(req_status), .req_int_err(req_int_err), .req_rd_len(req_rd_len),
    .feat_caps(feat_caps), .cmd_ready(cmd_ready), .restart_req(restart_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  logic [7:0] exp_b [0:1023];
  logic       exp_l [0:1023];
  int exp_n = 0;
  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] sent_status(input logic [15:0] code, input logic internal);
    logic [15:0] s;
    s = code;
    if (internal) s = 16'h8000 | (code & 16'h7fff);
    return s;
  endfunction

  task automatic push(input logic [7:0] b, input logic l);
    exp_b[exp_n] = b;
    exp_l[exp_n] = l;
    exp_n++;
  endtask

  task automatic build_xfer(input logic [15:0] st, input int n);
    int off;
    int ch;
    bit first;
    logic [15:0] fld;
    off = 0;
    first = 1;
    exp_n = 0;
    if (st != 16'd0) n = 0;
    do begin
      ch = n - off;
      if (ch > 60) ch = 60;
      push(first ? 8'd5 : 8'd6, 1'b0);
      push(8'd0, 1'b0);
      fld = first ? st : 16'(off);
      push(fld[7:0], 1'b0);
      push(fld[15:8], ch == 0);
      for (int i = 0; i < ch; i++) push(mem[off + i], i == ch - 1);
      off += ch;
      first = 0;
    end while (off < n);
  endtask

  task automatic build_cfg(input logic [5:0] f);
    exp_n = 0;
    push(8'd1, 1'b0); push(8'd0, 1'b0);
    push(8'(MAXW % 256), 1'b0); push(8'(MAXW / 256), 1'b0);
    push(8'(MAXR % 256), 1'b0); push(8'(MAXR / 256), 1'b0);
    push({2'b00, f}, 1'b0); push(8'd0, 1'b1);
  endtask

  task automatic build_cs(input logic [15:0] st);
    exp_n = 0;
    push(8'd8, 1'b0); push(8'd0, 1'b0);
    push(st[7:0], 1'b0); push(st[15:8], 1'b1);
  endtask

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [15:0] st, input logic ie,
                       input logic [15:0] n, input logic [5:0] f);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_status = st; req_int_err = ie;
    req_rd_len = n; feat_caps = f;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
  endtask

  task automatic collect(input string tag, input int rpct);
    int idx;
    int guard;
    bit r;
    bit stalled;
    bit stall_bad;
    bit mism;
    int bad_i;
    logic [8:0] bad_a;
    logic [8:0] bad_e;
    logic [8:0] held;
    idx = 0; guard = 0; stalled = 0; stall_bad = 0; mism = 0; bad_i = 0;
    bad_a = '0; bad_e = '0; held = '0;
    while (idx < exp_n && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (stalled && (!out_valid || {out_last, out_data} !== held)) stall_bad = 1;
      r = (($urandom % 100) < rpct);
      out_ready = r;
      if (out_valid) begin
        if (r) begin
          if (!mism && {out_last, out_data} !== {exp_l[idx], exp_b[idx]}) begin
            mism = 1; bad_i = idx;
            bad_a = {out_last, out_data};
            bad_e = {exp_l[idx], exp_b[idx]};
          end
          idx++;
          stalled = 0;
        end else begin
          stalled = 1;
          held = {out_last, out_data};
        end
      end else begin
        stalled = 0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    tests++;
    if (mism) begin
      fails++;
      $display("FAIL %s byte %0d actual last/data %h expected %h", tag, bad_i, bad_a, bad_e);
    end
    check(idx == exp_n, $sformatf("%s byte count actual %0d expected %0d", tag, idx, exp_n));
    check(!stall_bad, $sformatf("R9 %s stalled byte changed actual 1 expected 0", tag));
    check(cmd_ready === 1'b1 && out_valid === 1'b0,
          $sformatf("R1 %s idle after response actual ready=%b valid=%b expected 1/0",
                    tag, cmd_ready, out_valid));
  endtask

  task automatic quiet(input string tag, input int ncyc);
    bit seen;
    seen = 0;
    out_ready = 1'b1;
    repeat (ncyc) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    out_ready = 1'b0;
    check(!seen, $sformatf("%s stray output actual 1 expected 0", tag));
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    int n;
    void'($urandom(32'h5eed_0417));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_status = '0;
    req_int_err = 1'b0; req_rd_len = '0; feat_caps = '0; restart_req = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_ready === 1'b1 && out_valid === 1'b0,
          $sformatf("R1 reset state actual ready=%b valid=%b expected 1/0", cmd_ready, out_valid));
    rst_n = 1'b1;

    // R11: nothing held after reset
    pulse_restart();
    quiet("R11 restart after reset", 12);

    // R3 R4: 100-byte read gives a 64-byte start and a 44-byte continue at index 60
    build_xfer(16'd0, 100);
    issue(2'd0, 16'd0, 1'b0, 16'd100, 6'd0);
    collect("R4 read 100", 100);

    // R10: replay of the held transfer
    pulse_restart();
    collect("R10 replay read 100", 100);

    // R4: zero-length read gives a 4-byte start only
    build_xfer(16'd0, 0);
    issue(2'd0, 16'd0, 1'b0, 16'd0, 6'd0);
    collect("R4 read 0", 100);

    // R3 boundary counts
    build_xfer(16'd0, 60);
    issue(2'd0, 16'd0, 1'b0, 16'd60, 6'd0);
    collect("R3 read 60", 100);
    build_xfer(16'd0, 61);
    issue(2'd0, 16'd0, 1'b0, 16'd61, 6'd0);
    collect("R4 read 61", 100);
    build_xfer(16'd0, 120);
    issue(2'd0, 16'd0, 1'b0, 16'd120, 6'd0);
    collect("R4 read 120", 100);

    // R5: error status drops the payload
    build_xfer(16'd3, 200);
    issue(2'd0, 16'd3, 1'b0, 16'd200, 6'd0);
    collect("R5 error status", 100);

    // R6: internal error wrapping
    build_xfer(sent_status(16'hf234, 1'b1), 50);
    issue(2'd0, 16'hf234, 1'b1, 16'd50, 6'd0);
    collect("R6 internal error", 100);

    // R7: configuration, then a restart must be ignored
    build_cfg(6'h2d);
    issue(2'd1, 16'd0, 1'b0, 16'd0, 6'h2d);
    collect("R7 config", 100);
    pulse_restart();
    quiet("R11 restart after config", 12);

    // R8: chip-select acknowledgements
    build_cs(16'd0);
    issue(2'd2, 16'd0, 1'b0, 16'd0, 6'd0);
    collect("R8 chip select ok", 100);
    build_cs(16'd7);
    issue(2'd2, 16'd7, 1'b0, 16'd0, 6'd0);
    collect("R8 chip select err", 100);

    // R9: heavy backpressure on the largest read
    build_xfer(16'd0, MAXR);
    issue(2'd0, 16'd0, 1'b0, 16'(MAXR), 6'd0);
    collect("R9 read max stalled", 30);

    // R11: kind 3 emits nothing and keeps the held response; R10 replay afterwards
    build_xfer(16'd0, 80);
    issue(2'd0, 16'd0, 1'b0, 16'd80, 6'd0);
    collect("R4 read 80", 70);
    issue(2'd3, 16'd0, 1'b0, 16'd5, 6'd0);
    quiet("R11 kind 3 request", 12);
    pulse_restart();
    collect("R10 replay after kind 3", 70);

    // R11: restart while streaming is ignored
    build_xfer(16'd0, 150);
    issue(2'd0, 16'd0, 1'b0, 16'd150, 6'd0);
    pulse_restart();
    collect("R11 restart mid stream", 80);
    quiet("R11 no replay after mid-stream restart", 12);

    // Constrained random mix
    for (int it = 0; it < 40; it++) begin
      int k;
      logic ie;
      logic [5:0] f;
      k = $urandom % 10;
      n = $urandom % (MAXR + 1);
      st = (($urandom % 5) == 0) ? 16'(1 + $urandom % 10) : 16'd0;
      ie = (($urandom % 8) == 0);
      f = 6'($urandom);
      if (k < 6) begin
        build_xfer(sent_status(st, ie), n);
        issue(2'd0, st, ie, 16'(n), f);
        collect("R3 R4 random transfer", 40 + $urandom % 61);
        if (($urandom % 3) == 0) begin
          pulse_restart();
          collect("R10 random replay", 50);
        end
      end else if (k < 8) begin
        build_cfg(f);
        issue(2'd1, st, ie, 16'(n), f);
        collect("R7 random config", 60);
      end else begin
        build_cs(sent_status(st, ie));
        issue(2'd2, st, ie, 16'(n), f);
        collect("R8 random chip select", 60);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule